// File: doc/BRIEF.md
# CPU Debug Access Command Sequencer

This block sits between a debug requester and a scan host that shifts an 8-byte vector through a set of shadow registers beside a small CPU. The requester asks for one operation at a time through an opcode and operand fields. The block turns that request into one or more scan transactions. For each transaction it builds the send vector, sets the phase flags the scan host obeys, and waits for the host's acknowledge. It then picks the wanted bytes out of the returned vector. Registers and memory are reached indirectly. The CPU is held in takeover mode, and immediate-load, memory-load and write-enable instruction words are injected through the shadow instruction register.

Send vector layout, which the host and CPU decode: byte 7 is the control byte, byte 1 is the instruction high byte, byte 0 is the instruction low byte, and bytes 2 to 6 are always zero on the send side. On the receive side, byte k (k = 0..6) holds register slot 6-k: R0, R1, R2, R3, PC, IR high, IR low. A transaction is marked by four phase flags: pre-CPU clock, pre-scan clock, full scan, and post-CPU clock. A normal transaction sets the first three flags.

The controller has four states. IDLE moves on an accepted request to ISSUE, or to FINISH when the request is rejected. ISSUE (one cycle, `host_go` high) always moves to WAIT. WAIT stays until `host_ack`. It then moves back to ISSUE for the next step, or to FINISH after the last step. FINISH (one cycle, `done` high) returns to IDLE.

Top module: `dbg_access_seq`

## Requirements
- R1: After reset, and in every cycle with `busy` low, `host_tx` is all zero and `host_go`, `done` and `cmd_err` are low until a request arrives. The send vector is also zero in the `done` cycle.
- R2: Opcode 0 (write register) issues one normal transaction: control 0x02, instruction high 0xA0 OR (index shifted left 2), instruction low equal to `req_lo`.
- R3: Opcode 1 (write instruction register) issues one normal transaction: control 0x06, instruction high `req_hi`, instruction low `req_lo`.
- R4: Opcode 2 (read register) issues one normal transaction with control 0x02 and all other bytes zero. At `done`, `rd_word` equals {0x00, receive byte (6 - index)}.
- R5: Opcode 3 (read all) issues the same transaction as R4. At `done`, `rd_snapshot` equals receive bytes 6..0.
- R6: Opcode 4 (write memory) issues five normal transactions in this order: load R3 with `req_addr` (0xAC), load R2 with `req_hi` (0xA8), load R1 with `req_lo` (0xA4), control 0x02 with instruction high 0x02 (write enable), then control 0x02 with all else zero.
- R7: Opcode 5 (read memory) issues five normal transactions: load R3 with `req_addr`, instruction high 0xC8, instruction high 0xC4, then two plain register reads. At `done`, `rd_word` is {byte 4 of the fourth reply, byte 5 of the fifth reply}.
- R8: Opcode 6 (single step) issues three transactions: scan only with control 0x00, post-CPU clock only with a zero vector, then scan only with control 0x02.
- R9: Opcode 7, or index 7 with opcode 0 or 2, is rejected. `done` and `cmd_err` are high in the cycle after the request and no transaction is issued. `cmd_err` holds until the next accepted request, which clears it.
- R10: A request presented while `busy` is high is ignored. The running sequence is unchanged, and no transaction follows `done`.
- R11: `host_go` is a one-cycle pulse in the cycle after acceptance or after a non-final acknowledge. The vector and flags hold until `host_ack`. `done` comes one cycle after the final acknowledge, and `busy` is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_op | input | 3 | Operation code (0..6, 7 reserved) |
| req_idx | input | 3 | Register index for register operations |
| req_addr | input | 8 | Memory address |
| req_hi | input | 8 | High data byte / instruction high byte |
| req_lo | input | 8 | Low data byte / register value / instruction low byte |
| busy | output | 1 | Command in progress, including the done cycle |
| done | output | 1 | One-cycle completion pulse |
| cmd_err | output | 1 | Last request was rejected |
| rd_word | output | 16 | Read register or read memory result |
| rd_snapshot | output | 56 | Read-all result, slot bytes 6..0 |
| host_go | output | 1 | Launch one scan transaction |
| host_pre_cpu | output | 1 | Phase flag: pulse CPU clock before scan |
| host_pre_clk | output | 1 | Phase flag: one scan clock for parallel load |
| host_scan | output | 1 | Phase flag: full 64-bit shift |
| host_post_cpu | output | 1 | Phase flag: CPU clock then one scan clock after |
| host_tx | output | 64 | Send vector |
| host_ack | input | 1 | Transaction complete, `host_rx` valid |
| host_rx | input | 64 | Receive vector |

## Verification
A request sampled at a clock edge shows `host_go` in the next cycle. Each acknowledge sampled in WAIT produces either the next `host_go` or `done` one cycle later. Read results are registered at the acknowledge edge, so they are stable when `done` is seen. A rejected request raises `done` with `cmd_err` in the very next cycle. The bench plays the scan host, holding off its acknowledge by one to three cycles. It samples every output on the falling edge and records each launched vector with its flags. After `done`, it compares the whole transaction list and the read fields against expected values that a bench function computes per opcode and step. It then checks one idle cycle for a zero vector and no further launch.

// File: rtl/dbgseq_pkg.sv
package dbgseq_pkg;

    localparam int BYTE_W    = 8;
    localparam int VEC_BYTES = 8;
    localparam int VEC_W     = BYTE_W * VEC_BYTES;
    localparam int REG_SLOTS = 7;
    localparam int SNAP_W    = REG_SLOTS * BYTE_W;
    localparam int WORD_W    = 2 * BYTE_W;
    localparam int IDX_W     = $clog2(VEC_BYTES);
    localparam int OP_W      = 3;
    localparam int STEP_W    = 3;

    // byte positions decoded by the scan host and the CPU
    localparam int CTRL_POS = VEC_BYTES - 1;
    localparam int IRH_POS  = 1;
    localparam int IRL_POS  = 0;

    localparam logic [IDX_W-1:0] IDX_RESERVED = IDX_W'(VEC_BYTES - 1);
    localparam logic [IDX_W-1:0] SLOT_TOP     = IDX_W'(REG_SLOTS - 1);
    localparam logic [IDX_W-1:0] REG_ADDR     = IDX_W'(3);
    localparam logic [IDX_W-1:0] REG_DHI      = IDX_W'(2);
    localparam logic [IDX_W-1:0] REG_DLO      = IDX_W'(1);

    localparam logic [BYTE_W-1:0] CTRL_NONE     = 8'h00;
    localparam logic [BYTE_W-1:0] CTRL_TAKEOVER = 8'h02;
    localparam logic [BYTE_W-1:0] CTRL_IRWRITE  = 8'h06;
    localparam logic [BYTE_W-1:0] IRH_IMM_BASE  = 8'hA0;
    localparam logic [BYTE_W-1:0] IRH_WR_EN     = 8'h02;
    localparam logic [BYTE_W-1:0] IRH_MEM_TO_R2 = 8'hC8;
    localparam logic [BYTE_W-1:0] IRH_MEM_TO_R1 = 8'hC4;

    typedef enum logic [OP_W-1:0] {
        OP_WR_REG = 3'd0,
        OP_WR_IR  = 3'd1,
        OP_RD_REG = 3'd2,
        OP_RD_ALL = 3'd3,
        OP_WR_MEM = 3'd4,
        OP_RD_MEM = 3'd5,
        OP_STEP   = 3'd6,
        OP_BAD    = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        CAP_NONE,
        CAP_REG,
        CAP_ALL,
        CAP_MHI,
        CAP_MLO
    } cap_e;

    typedef struct packed {
        logic pre_cpu;
        logic pre_clk;
        logic scan;
        logic post_cpu;
    } phase_t;

    typedef struct packed {
        logic [BYTE_W-1:0] ctrl;
        logic [BYTE_W-1:0] irh;
        logic [BYTE_W-1:0] irl;
        phase_t            ph;
        cap_e              cap;
        logic              last;
    } txn_t;

    localparam phase_t PH_NORMAL = '{pre_cpu: 1'b1, pre_clk: 1'b1, scan: 1'b1, post_cpu: 1'b0};
    localparam phase_t PH_SCAN   = '{pre_cpu: 1'b0, pre_clk: 1'b0, scan: 1'b1, post_cpu: 1'b0};
    localparam phase_t PH_POST   = '{pre_cpu: 1'b0, pre_clk: 1'b0, scan: 1'b0, post_cpu: 1'b1};

    // instruction high byte for "load register r with immediate"
    function automatic logic [BYTE_W-1:0] imm_irh(input logic [IDX_W-1:0] r);
        return IRH_IMM_BASE | BYTE_W'({r, 2'b00});
    endfunction

    function automatic txn_t mk_txn(input phase_t ph, input logic [BYTE_W-1:0] c,
                                    input logic [BYTE_W-1:0] h, input logic [BYTE_W-1:0] l,
                                    input cap_e cap, input logic last);
        txn_t t;
        t.ctrl = c;
        t.irh  = h;
        t.irl  = l;
        t.ph   = ph;
        t.cap  = cap;
        t.last = last;
        return t;
    endfunction

    function automatic logic is_reject(input op_e op, input logic [IDX_W-1:0] idx);
        return (op == OP_BAD) ||
               (((op == OP_WR_REG) || (op == OP_RD_REG)) && (idx == IDX_RESERVED));
    endfunction

endpackage

// File: rtl/dbgseq_plan.sv
module dbgseq_plan
    import dbgseq_pkg::*;
(
    input  op_e               op,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] addr,
    input  logic [BYTE_W-1:0] hi,
    input  logic [BYTE_W-1:0] lo,
    input  logic [STEP_W-1:0] step,
    output txn_t              txn
);

    always_comb begin
        txn = mk_txn(PH_NORMAL, CTRL_TAKEOVER, '0, '0, CAP_NONE, 1'b1);
        unique case (op)
            OP_WR_REG: txn = mk_txn(PH_NORMAL, CTRL_TAKEOVER, imm_irh(idx), lo, CAP_NONE, 1'b1);
            OP_WR_IR:  txn = mk_txn(PH_NORMAL, CTRL_IRWRITE, hi, lo, CAP_NONE, 1'b1);
            OP_RD_REG: txn = mk_txn(PH_NORMAL, CTRL_TAKEOVER, '0, '0, CAP_REG, 1'b1);
            OP_RD_ALL: txn = mk_txn(PH_NORMAL, CTRL_TAKEOVER, '0, '0, CAP_ALL, 1'b1);
            OP_WR_MEM: begin
                unique case (step)
                    STEP_W'(0): txn = mk_txn(PH_NORMAL, CTRL_TAKEOVER, imm_irh(REG_ADDR), addr, CAP_NONE, 1'b0);
                    STEP_W'(1): txn = mk_txn(PH_NORMAL, CTRL_TAKEOVER, imm_irh(REG_DHI), hi, CAP_NONE, 1'b0);
                    STEP_W'(2): txn = mk_txn(PH_NORMAL, CTRL_TAKEOVER, imm_irh(REG_DLO), lo, CAP_NONE, 1'b0);
                    STEP_W'(3): txn = mk_txn(PH_NORMAL, CTRL_TAKEOVER, IRH_WR_EN, '0, CAP_NONE, 1'b0);
                    default:    txn = mk_txn(PH_NORMAL, CTRL_TAKEOVER, '0, '0, CAP_NONE, 1'b1);
                endcase
            end
            OP_RD_MEM: begin
                unique case (step)
                    STEP_W'(0): txn = mk_txn(PH_NORMAL, CTRL_TAKEOVER, imm_irh(REG_ADDR), addr, CAP_NONE, 1'b0);
                    STEP_W'(1): txn = mk_txn(PH_NORMAL, CTRL_TAKEOVER, IRH_MEM_TO_R2, '0, CAP_NONE, 1'b0);
                    STEP_W'(2): txn = mk_txn(PH_NORMAL, CTRL_TAKEOVER, IRH_MEM_TO_R1, '0, CAP_NONE, 1'b0);
                    STEP_W'(3): txn = mk_txn(PH_NORMAL, CTRL_TAKEOVER, '0, '0, CAP_MHI, 1'b0);
                    default:    txn = mk_txn(PH_NORMAL, CTRL_TAKEOVER, '0, '0, CAP_MLO, 1'b1);
                endcase
            end
            OP_STEP: begin
                unique case (step)
                    STEP_W'(0): txn = mk_txn(PH_SCAN, CTRL_NONE, '0, '0, CAP_NONE, 1'b0);
                    STEP_W'(1): txn = mk_txn(PH_POST, CTRL_NONE, '0, '0, CAP_NONE, 1'b0);
                    default:    txn = mk_txn(PH_SCAN, CTRL_TAKEOVER, '0, '0, CAP_NONE, 1'b1);
                endcase
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dbgseq_txvec.sv
module dbgseq_txvec
    import dbgseq_pkg::*;
(
    input  txn_t             txn,
    input  logic             active,
    output logic [VEC_W-1:0] tx,
    output phase_t           ph
);

    for (genvar b = 0; b < VEC_BYTES; b++) begin : g_byte
        if (b == CTRL_POS) begin : g_ctrl
            assign tx[b*BYTE_W +: BYTE_W] = active ? txn.ctrl : '0;
        end else if (b == IRH_POS) begin : g_irh
            assign tx[b*BYTE_W +: BYTE_W] = active ? txn.irh : '0;
        end else if (b == IRL_POS) begin : g_irl
            assign tx[b*BYTE_W +: BYTE_W] = active ? txn.irl : '0;
        end else begin : g_zero
            assign tx[b*BYTE_W +: BYTE_W] = '0;
        end
    end

    assign ph = active ? txn.ph : '0;

endmodule

// File: rtl/dbgseq_capture.sv
module dbgseq_capture
    import dbgseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  cap_e              kind,
    input  logic [IDX_W-1:0]  idx,
    input  logic [SNAP_W-1:0] rx_low,
    output logic [WORD_W-1:0] word,
    output logic [SNAP_W-1:0] snap
);

    localparam logic [IDX_W-1:0] MHI_SLOT = SLOT_TOP - REG_DHI;
    localparam logic [IDX_W-1:0] MLO_SLOT = SLOT_TOP - REG_DLO;

    logic [BYTE_W-1:0] slot [VEC_BYTES];

    for (genvar g = 0; g < VEC_BYTES; g++) begin : g_slot
        if (g < REG_SLOTS) begin : g_live
            assign slot[g] = rx_low[g*BYTE_W +: BYTE_W];
        end else begin : g_pad
            assign slot[g] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
            snap <= '0;
        end else if (cap_en) begin
            unique case (kind)
                CAP_REG: word <= {{BYTE_W{1'b0}}, slot[SLOT_TOP - idx]};
                CAP_ALL: snap <= rx_low;
                CAP_MHI: word[WORD_W-1:BYTE_W] <= slot[MHI_SLOT];
                CAP_MLO: word[BYTE_W-1:0] <= slot[MLO_SLOT];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dbgseq_fsm.sv
module dbgseq_fsm
    import dbgseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  op_e               req_op,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [BYTE_W-1:0] req_addr,
    input  logic [BYTE_W-1:0] req_hi,
    input  logic [BYTE_W-1:0] req_lo,
    input  logic              host_ack,
    input  logic              last_step,
    output op_e               cur_op,
    output logic [IDX_W-1:0]  cur_idx,
    output logic [BYTE_W-1:0] cur_addr,
    output logic [BYTE_W-1:0] cur_hi,
    output logic [BYTE_W-1:0] cur_lo,
    output logic [STEP_W-1:0] cur_step,
    output logic              busy,
    output logic              done,
    output logic              issue,
    output logic              active,
    output logic              capture,
    output logic              err
);

    typedef enum logic [1:0] {
        S_IDLE,
        S_ISSUE,
        S_WAIT,
        S_FINISH
    } state_e;

    state_e state;
    state_e nxt;
    logic   accept;
    logic   reject_now;

    assign accept     = (state == S_IDLE) && req_valid;
    assign reject_now = is_reject(req_op, req_idx);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // request latch, step counter and error flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_op   <= OP_WR_REG;
            cur_idx  <= '0;
            cur_addr <= '0;
            cur_hi   <= '0;
            cur_lo   <= '0;
            cur_step <= '0;
            err      <= 1'b0;
        end else if (accept) begin
            cur_op   <= req_op;
            cur_idx  <= req_idx;
            cur_addr <= req_addr;
            cur_hi   <= req_hi;
            cur_lo   <= req_lo;
            cur_step <= '0;
            err      <= reject_now;
        end else if ((state == S_WAIT) && host_ack && !last_step) begin
            cur_step <= cur_step + 1'b1;
        end
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (req_valid) nxt = reject_now ? S_FINISH : S_ISSUE;
            S_ISSUE:  nxt = S_WAIT;
            S_WAIT:   if (host_ack) nxt = last_step ? S_FINISH : S_ISSUE;
            S_FINISH: nxt = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy   = 1'b1;
        done   = 1'b0;
        issue  = 1'b0;
        active = 1'b0;
        unique case (state)
            S_IDLE:   busy = 1'b0;
            S_ISSUE:  begin issue = 1'b1; active = 1'b1; end
            S_WAIT:   active = 1'b1;
            S_FINISH: done = 1'b1;
        endcase
    end

    assign capture = (state == S_WAIT) && host_ack;

endmodule

// File: rtl/dbg_access_seq.sv
module dbg_access_seq
    import dbgseq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [OP_W-1:0]      req_op,
    input  logic [IDX_W-1:0]     req_idx,
    input  logic [BYTE_W-1:0]    req_addr,
    input  logic [BYTE_W-1:0]    req_hi,
    input  logic [BYTE_W-1:0]    req_lo,
    output logic                 busy,
    output logic                 done,
    output logic                 cmd_err,
    output logic [WORD_W-1:0]    rd_word,
    output logic [SNAP_W-1:0]    rd_snapshot,
    output logic                 host_go,
    output logic                 host_pre_cpu,
    output logic                 host_pre_clk,
    output logic                 host_scan,
    output logic                 host_post_cpu,
    output logic [VEC_W-1:0]     host_tx,
    input  logic                 host_ack,
    input  logic [VEC_W-1:0]     host_rx
);

    op_e               cur_op;
    logic [IDX_W-1:0]  cur_idx;
    logic [BYTE_W-1:0] cur_addr;
    logic [BYTE_W-1:0] cur_hi;
    logic [BYTE_W-1:0] cur_lo;
    logic [STEP_W-1:0] cur_step;
    logic              active;
    logic              capture;
    txn_t              txn;
    phase_t            ph;
    logic              rx_ctrl_unused;

    assign rx_ctrl_unused = ^host_rx[VEC_W-1:SNAP_W];

    dbgseq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_op    (op_e'(req_op)),
        .req_idx   (req_idx),
        .req_addr  (req_addr),
        .req_hi    (req_hi),
        .req_lo    (req_lo),
        .host_ack  (host_ack),
        .last_step (txn.last),
        .cur_op    (cur_op),
        .cur_idx   (cur_idx),
        .cur_addr  (cur_addr),
        .cur_hi    (cur_hi),
        .cur_lo    (cur_lo),
        .cur_step  (cur_step),
        .busy      (busy),
        .done      (done),
        .issue     (host_go),
        .active    (active),
        .capture   (capture),
        .err       (cmd_err)
    );

    dbgseq_plan u_plan (
        .op   (cur_op),
        .idx  (cur_idx),
        .addr (cur_addr),
        .hi   (cur_hi),
        .lo   (cur_lo),
        .step (cur_step),
        .txn  (txn)
    );

    dbgseq_txvec u_txvec (
        .txn    (txn),
        .active (active),
        .tx     (host_tx),
        .ph     (ph)
    );

    assign host_pre_cpu  = ph.pre_cpu;
    assign host_pre_clk  = ph.pre_clk;
    assign host_scan     = ph.scan;
    assign host_post_cpu = ph.post_cpu;

    dbgseq_capture u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (capture),
        .kind   (txn.cap),
        .idx    (cur_idx),
        .rx_low (host_rx[SNAP_W-1:0]),
        .word   (rd_word),
        .snap   (rd_snapshot)
    );

endmodule

// File: rtl/dbg_access_seq_chk.sv
module dbg_access_seq_chk
    import dbgseq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [OP_W-1:0]   req_op,
    input logic [IDX_W-1:0]  req_idx,
    input logic              busy,
    input logic              done,
    input logic              cmd_err,
    input logic              host_go,
    input logic              host_pre_cpu,
    input logic              host_pre_clk,
    input logic              host_scan,
    input logic              host_post_cpu,
    input logic [VEC_W-1:0]  host_tx,
    input logic              host_ack
);

    logic bad_req;
    assign bad_req = (req_op == 3'd7) ||
                     (((req_op == 3'd0) || (req_op == 3'd2)) && (req_idx == 3'd7));

    // R1
    idle_tx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy || done) |-> (host_tx == '0 && !host_go));

    // R2
    mid_bytes_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_go |-> (host_tx[VEC_W-BYTE_W-1:2*BYTE_W] == '0));

    // R8
    post_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_go && host_post_cpu) |-> (!host_scan && !host_pre_cpu && !host_pre_clk && host_tx == '0));

    // R9
    reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && bad_req) |=> (done && cmd_err && !host_go));

    // R10
    done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!busy && !host_go));

    // R11
    go_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_go |=> !host_go);

    // R11
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && !host_go && $past(busy) && !$past(host_ack)) |-> $stable(host_tx));

endmodule

bind dbg_access_seq dbg_access_seq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_op        (req_op),
    .req_idx       (req_idx),
    .busy          (busy),
    .done          (done),
    .cmd_err       (cmd_err),
    .host_go       (host_go),
    .host_pre_cpu  (host_pre_cpu),
    .host_pre_clk  (host_pre_clk),
    .host_scan     (host_scan),
    .host_post_cpu (host_post_cpu),
    .host_tx       (host_tx),
    .host_ack      (host_ack)
);

// File: tb/dbg_access_seq_test.sv
module dbg_access_seq_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [2:0]  req_op;
    logic [2:0]  req_idx;
    logic [7:0]  req_addr, req_hi, req_lo;
    logic        busy, done, cmd_err;
    logic [15:0] rd_word;
    logic [55:0] rd_snapshot;
    logic        host_go, host_pre_cpu, host_pre_clk, host_scan, host_post_cpu;
    logic [63:0] host_tx;
    logic        host_ack;
    logic [63:0] host_rx;

    int n_run  = 0;
    int n_fail = 0;
    int cyc    = 0;

    logic [67:0] got [0:7];
    logic [63:0] rxv [0:7];
    int          ntx;
    int          done_wait;

    dbg_access_seq uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_idx(req_idx),
        .req_addr(req_addr), .req_hi(req_hi), .req_lo(req_lo), .busy(busy), .done(done),
        .cmd_err(cmd_err), .rd_word(rd_word), .rd_snapshot(rd_snapshot), .host_go(host_go),
        .host_pre_cpu(host_pre_cpu), .host_pre_clk(host_pre_clk), .host_scan(host_scan),
        .host_post_cpu(host_post_cpu), .host_tx(host_tx), .host_ack(host_ack), .host_rx(host_rx)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            n_run++;
            n_fail++;
            $display("FAIL R11 watchdog expired: actual=%0d cycles expected<%0d", cyc, WATCHDOG);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [67:0] act, input logic [67:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string op_tag(input logic [2:0] op);
        case (op)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd5: return "R7";
            3'd6: return "R8";
            default: return "R9";
        endcase
    endfunction

    function automatic int exp_count(input logic [2:0] op);
        case (op)
            3'd4, 3'd5: return 5;
            3'd6:       return 3;
            3'd7:       return 0;
            default:    return 1;
        endcase
    endfunction

    function automatic logic [67:0] mk(input logic [3:0] f, input logic [7:0] c,
                                       input logic [7:0] h, input logic [7:0] l);
        return {f, c, 40'h0, h, l};
    endfunction

    // flags order {pre_cpu, pre_clk, scan, post_cpu}
    function automatic logic [67:0] exp_txn(input logic [2:0] op, input logic [2:0] idx,
                                            input logic [7:0] a, input logic [7:0] h,
                                            input logic [7:0] l, input int s);
        case (op)
            3'd0: return mk(4'b1110, 8'h02, 8'hA0 | {3'b000, idx, 2'b00}, l);
            3'd1: return mk(4'b1110, 8'h06, h, l);
            3'd2, 3'd3: return mk(4'b1110, 8'h02, 8'h00, 8'h00);
            3'd4: case (s)
                      0: return mk(4'b1110, 8'h02, 8'hAC, a);
                      1: return mk(4'b1110, 8'h02, 8'hA8, h);
                      2: return mk(4'b1110, 8'h02, 8'hA4, l);
                      3: return mk(4'b1110, 8'h02, 8'h02, 8'h00);
                      default: return mk(4'b1110, 8'h02, 8'h00, 8'h00);
                  endcase
            3'd5: case (s)
                      0: return mk(4'b1110, 8'h02, 8'hAC, a);
                      1: return mk(4'b1110, 8'h02, 8'hC8, 8'h00);
                      2: return mk(4'b1110, 8'h02, 8'hC4, 8'h00);
                      default: return mk(4'b1110, 8'h02, 8'h00, 8'h00);
                  endcase
            default: case (s)
                      0: return mk(4'b0010, 8'h00, 8'h00, 8'h00);
                      1: return mk(4'b0001, 8'h00, 8'h00, 8'h00);
                      default: return mk(4'b0010, 8'h02, 8'h00, 8'h00);
                  endcase
        endcase
    endfunction

    // plays the scan host until done; caller is at a falling edge
    task automatic run_cmd(input logic [2:0] op, input logic [2:0] idx, input logic [7:0] a,
                           input logic [7:0] h, input logic [7:0] l, input bit inject, input int lat);
        bit fresh;
        int guard;
        int cur;
        ntx = 0;
        done_wait = 0;
        guard = 0;
        for (int k = 0; k < 8; k++) rxv[k] = {$urandom(), $urandom()};
        req_valid = 1'b1; req_op = op; req_idx = idx; req_addr = a; req_hi = h; req_lo = l;
        @(negedge clk);
        req_valid = 1'b0;
        fresh = 1'b1;
        forever begin
            if (!fresh) begin
                @(negedge clk);
                done_wait++;
            end
            fresh = 1'b0;
            if (done) break;
            if (host_go) begin
                cur = ntx;
                if (ntx < 8) got[ntx] = {host_pre_cpu, host_pre_clk, host_scan, host_post_cpu, host_tx};
                ntx++;
                if (inject && ntx == 1) begin
                    req_valid = 1'b1; req_op = 3'd1; req_idx = 3'd0; req_hi = 8'hFF; req_lo = 8'hEE;
                end
                for (int w = 0; w < lat; w++) begin
                    @(negedge clk);
                    done_wait++;
                end
                req_valid = 1'b0;
                host_rx = rxv[cur < 8 ? cur : 7];
                host_ack = 1'b1;
                @(negedge clk);
                done_wait++;
                host_ack = 1'b0;
                fresh = 1'b1;
            end
            guard++;
            if (guard > 100) break;
        end
    endtask

    task automatic check_cmd(input logic [2:0] op, input logic [2:0] idx, input logic [7:0] a,
                             input logic [7:0] h, input logic [7:0] l);
        string t;
        int n;
        t = op_tag(op);
        n = exp_count(op);
        chk(ntx == n, {t, " transaction count"}, 68'(ntx), 68'(n));
        for (int s = 0; s < n && s < ntx; s++)
            chk(got[s] == exp_txn(op, idx, a, h, l, s), {t, " transaction"}, got[s], exp_txn(op, idx, a, h, l, s));
        // R9 accepted request clears the error flag
        chk(cmd_err == 1'b0, "R9 error cleared", 68'(cmd_err), 68'(0));
        if (op == 3'd2)
            chk(rd_word == {8'h00, rxv[0][8*(6-idx) +: 8]}, "R4 read register", 68'(rd_word),
                68'({8'h00, rxv[0][8*(6-idx) +: 8]}));
        if (op == 3'd3)
            chk(rd_snapshot == rxv[0][55:0], "R5 read all", 68'(rd_snapshot), 68'(rxv[0][55:0]));
        if (op == 3'd5)
            chk(rd_word == {rxv[3][39:32], rxv[4][47:40]}, "R7 read memory", 68'(rd_word),
                68'({rxv[3][39:32], rxv[4][47:40]}));
        @(negedge clk);
        // R1 R10 nothing launched and vector zero once idle
        chk(!busy && !host_go && host_tx == '0, "R1 R10 idle after done",
            68'({busy, host_go, host_tx}), 68'(0));
    endtask

    task automatic check_reject(input logic [2:0] op, input logic [2:0] idx);
        run_cmd(op, idx, 8'h11, 8'h22, 8'h33, 1'b0, 1);
        chk(ntx == 0 && done_wait == 0, "R9 reject without transaction", 68'({ntx[15:0], done_wait[15:0]}), 68'(0));
        chk(cmd_err == 1'b1, "R9 error flag", 68'(cmd_err), 68'(1));
        @(negedge clk);
        chk(!busy && host_tx == '0, "R1 idle after reject", 68'({busy, host_tx}), 68'(0));
    endtask

    task automatic do_cmd(input logic [2:0] op, input logic [2:0] idx, input logic [7:0] a,
                          input logic [7:0] h, input logic [7:0] l, input bit inject, input int lat);
        run_cmd(op, idx, a, h, l, inject, lat);
        check_cmd(op, idx, a, h, l);
    endtask

    initial begin
        int seed_init;
        seed_init = $urandom(32'd2718);
        rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_idx = '0;
        req_addr = '0; req_hi = '0; req_lo = '0; host_ack = 1'b0; host_rx = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !host_go && !cmd_err && host_tx == '0 && rd_word == '0,
            "R1 reset state", 68'({busy, done, host_go, cmd_err, rd_word}), 68'(0));

        do_cmd(3'd0, 3'd5, 8'h00, 8'h00, 8'h3C, 1'b0, 1);   // R2
        do_cmd(3'd0, 3'd0, 8'h00, 8'h00, 8'hFF, 1'b0, 2);   // R2
        do_cmd(3'd1, 3'd0, 8'h00, 8'h12, 8'h34, 1'b0, 1);   // R3
        do_cmd(3'd2, 3'd0, 8'h00, 8'h00, 8'h00, 1'b0, 3);   // R4 slot R0
        do_cmd(3'd2, 3'd6, 8'h00, 8'h00, 8'h00, 1'b0, 1);   // R4 slot IR low
        do_cmd(3'd3, 3'd0, 8'h00, 8'h00, 8'h00, 1'b0, 2);   // R5
        do_cmd(3'd4, 3'd0, 8'h80, 8'hDE, 8'hAD, 1'b0, 1);   // R6
        do_cmd(3'd5, 3'd0, 8'h7F, 8'h00, 8'h00, 1'b0, 2);   // R7
        do_cmd(3'd6, 3'd0, 8'h00, 8'h00, 8'h00, 1'b0, 1);   // R8

        check_reject(3'd0, 3'd7);                             // R9
        do_cmd(3'd1, 3'd0, 8'h00, 8'hA5, 8'h5A, 1'b0, 1);   // R9 cleared
        check_reject(3'd2, 3'd7);                             // R9
        check_reject(3'd7, 3'd1);                             // R9
        do_cmd(3'd3, 3'd0, 8'h00, 8'h00, 8'h00, 1'b0, 1);

        do_cmd(3'd5, 3'd0, 8'h44, 8'h00, 8'h00, 1'b1, 3);   // R10 request while busy
        do_cmd(3'd6, 3'd0, 8'h00, 8'h00, 8'h00, 1'b1, 2);   // R10
        do_cmd(3'd0, 3'd3, 8'h00, 8'h00, 8'h99, 1'b1, 1);   // R10

        for (int i = 0; i < 40; i++) begin
            logic [2:0] op;
            logic [2:0] idx;
            op  = 3'($urandom_range(0, 6));
            idx = 3'($urandom_range(0, 6));
            do_cmd(op, idx, 8'($urandom()), 8'($urandom()), 8'($urandom()),
                   ($urandom_range(0, 3) == 0), int'($urandom_range(1, 3)));
        end

        summary();
        $finish;
    end

endmodule